// File: doc/BRIEF.md
# DE-only panel timing generator

This block produces the pixel-rate timing for a flat panel that is driven in data-enable-only mode. A horizontal and a vertical counter step on every pixel clock. Their decode gives a data-enable strobe that is high only across the visible pixels, plus the current pixel column and row, and a single-clock strobe that marks the first visible pixel of every frame. The panel takes no sync pulses, so both sync outputs are held low and all timing is carried by data enable.

The visible area is fixed by parameters (1366 x 768 by default). The horizontal blanking length (in clocks) and the vertical blanking length (in lines) come from input ports. Each value is clamped to the panel's allowed window: 70 to 570 clocks and 2 to 120 lines by default. An error flag reports when either requested value had to be clamped. Blanking values are sampled during reset and again on the last clock of every frame, so a change made during a frame takes effect with the next frame.

Top module: `panel_de_timer`

## Requirements
- R1: While reset is held, de, frame_start, px_x and px_y are zero; the blanking lengths and cfg_err are loaded from the inputs present at that time.
- R2: Every visible line shows H_ACTIVE consecutive clocks of de high with px_x running 0 to H_ACTIVE-1, followed by exactly the latched horizontal blanking count of clocks with de low.
- R3: A frame has V_ACTIVE visible lines followed by the latched vertical blanking count of lines, and de stays low for every clock of those blanking lines.
- R4: px_x counts up by one per clock to H_ACTIVE + hblank - 1 and then returns to 0; px_y advances by one on each such return and returns to 0 after V_ACTIVE + vblank - 1.
- R5: frame_start is high for one clock per frame, in the same clock as de high with px_x = 0 and px_y = 0.
- R6: hsync and vsync are 0 at all times.
- R7: A horizontal blanking request below HB_MIN is used as HB_MIN, one above HB_MAX is used as HB_MAX, and in both cases cfg_err is 1 for that frame.
- R8: A vertical blanking request below VB_MIN is used as VB_MIN, one above VB_MAX is used as VB_MAX, and in both cases cfg_err is 1 for that frame.
- R9: A blanking change applied after a frame has started leaves that frame's length unchanged; the new values set the length of the following frame.
- R10: cfg_err changes only at reset or at a frame boundary. From that point it is 1 exactly when the hblank or vblank value latched there was out of range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hblank_len | input | HBW | Requested horizontal blanking length in clocks |
| vblank_len | input | VBW | Requested vertical blanking length in lines |
| de | output | 1 | Data enable, high on visible pixels |
| px_x | output | HW | Current column, including blanking clocks |
| px_y | output | VW | Current row, including blanking lines |
| frame_start | output | 1 | One-clock strobe on the first visible pixel of a frame |
| hsync | output | 1 | Horizontal sync, constant low |
| vsync | output | 1 | Vertical sync, constant low |
| cfg_err | output | 1 | The blanking in use was clamped from an out-of-range request |

## Verification
The assertions assume that the blanking inputs are only sampled at reset and at frame boundaries, so they allow those inputs to change at any clock. They also assume reset is held for at least one edge before any output is relied on. The stimulus changes the inputs only on falling clock edges, with reset held for several clocks. It applies in-range, below-minimum and above-maximum values on both axes, some of them in the middle of a frame to exercise the latching boundary. The bench instance uses a small visible area and small limits so that many whole frames fit in a short run.

// File: rtl/de_timing_pkg.sv
// Package: shared types and helpers for the DE-only panel timing generator.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package de_timing_pkg;

    // Position of the raster scan within a frame.
    typedef enum logic [1:0] {
        RGN_ACTIVE = 2'd0,
        RGN_HBLANK = 2'd1,
        RGN_VBLANK = 2'd2
    } region_e;

    // Bits needed to hold values 0 .. n-1 (at least one bit).
    function automatic int bits_for(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/blank_limiter.sv
// Module: blank_limiter
// Clamps a requested blanking length into [LO, HI] and flags the clamp.
// Assumes: LO <= HI and HI fits in W bits. Purely combinational.
module blank_limiter #(
    parameter int W  = 10,
    parameter int LO = 70,
    parameter int HI = 570
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] sat,
    output logic         out_of_range
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    logic below;
    logic above;

    // A zero low limit can never be undershot; the parameter picks the variant.
    generate
        if (LO == 0) begin : g_no_low
            assign below = 1'b0;
        end else begin : g_low
            assign below = (raw < LO_V);
        end
    endgenerate

    assign above = (raw > HI_V);

    // Pick the nearest limit when the request falls outside the window.
    always_comb begin
        if (below) begin
            sat = LO_V;
        end else if (above) begin
            sat = HI_V;
        end else begin
            sat = raw;
        end
        out_of_range = below | above;
    end

endmodule

// File: rtl/span_counter.sv
// Module: span_counter
// Counts 0..last on each advance, then wraps to 0; flags the last value.
// Assumes: last only changes while the count is at 0 or when it is ever
// larger than the count (the parent updates it at frame wrap).
module span_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] last,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    assign at_last = (cnt == last);

    // Advance or wrap the position count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

    // R4: the count never passes its end value.
    p_span_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);

    // R4: advancing from the end value lands on zero.
    p_span_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && at_last) |=> (cnt == '0));

    // R4: without an advance the count holds.
    p_span_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(cnt));

endmodule

// File: rtl/panel_de_timer.sv
// Module: panel_de_timer
// Generates data enable, pixel coordinates and a frame-start strobe for a
// panel driven with no sync pulses. Blanking lengths are clamped, latched
// at reset and at each frame end, and drive the line and frame totals.
// Assumes: pixel clock is the only clock; reset is synchronous, active low.
module panel_de_timer
    import de_timing_pkg::*;
#(
    parameter int H_ACTIVE = 1366,
    parameter int V_ACTIVE = 768,
    parameter int HB_MIN   = 70,
    parameter int HB_MAX   = 570,
    parameter int VB_MIN   = 2,
    parameter int VB_MAX   = 120,
    localparam int HBW     = bits_for(HB_MAX + 1),
    localparam int VBW     = bits_for(VB_MAX + 1),
    localparam int HW      = bits_for(H_ACTIVE + HB_MAX),
    localparam int VW      = bits_for(V_ACTIVE + VB_MAX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [HBW-1:0] hblank_len,
    input  logic [VBW-1:0] vblank_len,
    output logic           de,
    output logic [HW-1:0]  px_x,
    output logic [VW-1:0]  px_y,
    output logic           frame_start,
    output logic           hsync,
    output logic           vsync,
    output logic           cfg_err
);
    localparam logic [HW-1:0] H_ACT_V = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_ACT_V = VW'(V_ACTIVE);

    logic [HBW-1:0] hb_sat, cur_hb;
    logic [VBW-1:0] vb_sat, cur_vb;
    logic           hb_bad, vb_bad;
    logic [HW-1:0]  hcnt, h_last;
    logic [VW-1:0]  vcnt, v_last;
    logic           h_end, v_end, frame_end;
    region_e        rgn;

    blank_limiter #(.W(HBW), .LO(HB_MIN), .HI(HB_MAX)) i_hlim (
        .raw(hblank_len), .sat(hb_sat), .out_of_range(hb_bad)
    );

    blank_limiter #(.W(VBW), .LO(VB_MIN), .HI(VB_MAX)) i_vlim (
        .raw(vblank_len), .sat(vb_sat), .out_of_range(vb_bad)
    );

    // Latch the clamped blanking and its error at reset and at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            cur_hb  <= hb_sat;
            cur_vb  <= vb_sat;
            cfg_err <= hb_bad | vb_bad;
        end
    end

    assign h_last = H_ACT_V + HW'(cur_hb) - 1'b1;
    assign v_last = V_ACT_V + VW'(cur_vb) - 1'b1;

    span_counter #(.W(HW)) i_hcnt (
        .clk(clk), .rst_n(rst_n), .adv(1'b1), .last(h_last),
        .cnt(hcnt), .at_last(h_end)
    );

    span_counter #(.W(VW)) i_vcnt (
        .clk(clk), .rst_n(rst_n), .adv(h_end), .last(v_last),
        .cnt(vcnt), .at_last(v_end)
    );

    assign frame_end = h_end & v_end;

    // Classify the current scan position.
    always_comb begin
        if (vcnt >= V_ACT_V) begin
            rgn = RGN_VBLANK;
        end else if (hcnt >= H_ACT_V) begin
            rgn = RGN_HBLANK;
        end else begin
            rgn = RGN_ACTIVE;
        end
    end

    // Register the decoded outputs one clock behind the counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            de          <= 1'b0;
            px_x        <= '0;
            px_y        <= '0;
            frame_start <= 1'b0;
        end else begin
            de          <= (rgn == RGN_ACTIVE);
            px_x        <= hcnt;
            px_y        <= vcnt;
            frame_start <= (hcnt == '0) && (vcnt == '0);
        end
    end

    assign hsync = 1'b0;
    assign vsync = 1'b0;

    // R3: vertical blanking rows never carry data enable.
    p_vblank_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (px_y >= V_ACT_V) |-> !de);

    // R2: horizontal blanking columns never carry data enable.
    p_hblank_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (px_x >= H_ACT_V) |-> !de);

    // R5: the frame strobe sits on the first visible pixel.
    p_fs_origin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (de && px_x == '0 && px_y == '0));

    // R5: the frame strobe lasts a single clock.
    p_fs_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    // R7: latched horizontal blanking stays inside its window.
    p_hb_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_hb >= HBW'(HB_MIN)) && (cur_hb <= HBW'(HB_MAX)));

    // R8: latched vertical blanking stays inside its window.
    p_vb_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_vb >= VBW'(VB_MIN)) && (cur_vb <= VBW'(VB_MAX)));

    // R9: blanking in use only changes across a frame end.
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> ($stable(cur_hb) && $stable(cur_vb)));

    // R10: the error flag only changes across a frame end.
    p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(cfg_err));

endmodule

// File: tb/test_panel_de_timer.sv
// Bench: behavioural reference model compared every clock, plus frame-length
// checks for each blanking scenario.
module test_panel_de_timer;
    localparam int CLK_PERIOD = 10;
    localparam int HA = 8;
    localparam int VA = 4;
    localparam int HMIN = 3;
    localparam int HMAX = 9;
    localparam int VMIN = 2;
    localparam int VMAX = 4;
    localparam int HBW = 4;
    localparam int VBW = 3;
    localparam int HW = 5;
    localparam int VW = 3;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [HBW-1:0] hb_in = 4'd5;
    logic [VBW-1:0] vb_in = 3'd3;
    logic de, frame_start, hsync, vsync, cfg_err;
    logic [HW-1:0] px_x;
    logic [VW-1:0] px_y;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    // reference model state
    int m_h = 0, m_v = 0, m_hb = 0, m_vb = 0;
    int e_de = 0, e_x = 0, e_y = 0, e_fs = 0, e_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    panel_de_timer #(
        .H_ACTIVE(HA), .V_ACTIVE(VA), .HB_MIN(HMIN), .HB_MAX(HMAX),
        .VB_MIN(VMIN), .VB_MAX(VMAX)
    ) i_panel_de_timer (
        .clk(clk), .rst_n(rst_n), .hblank_len(hb_in), .vblank_len(vb_in),
        .de(de), .px_x(px_x), .px_y(px_y), .frame_start(frame_start),
        .hsync(hsync), .vsync(vsync), .cfg_err(cfg_err)
    );

    function automatic int clamp(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model stepped on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_h = 0; m_v = 0;
            m_hb = clamp(int'(hb_in), HMIN, HMAX);
            m_vb = clamp(int'(vb_in), VMIN, VMAX);
            e_err = (int'(hb_in) != m_hb || int'(vb_in) != m_vb) ? 1 : 0;
            e_de = 0; e_x = 0; e_y = 0; e_fs = 0;
            cmp_on = 1'b1;
        end else begin
            e_de = (m_h < HA && m_v < VA) ? 1 : 0;
            e_x = m_h; e_y = m_v;
            e_fs = (m_h == 0 && m_v == 0) ? 1 : 0;
            if (m_h == HA + m_hb - 1) begin
                m_h = 0;
                if (m_v == VA + m_vb - 1) begin
                    m_v = 0;
                    m_hb = clamp(int'(hb_in), HMIN, HMAX);
                    m_vb = clamp(int'(vb_in), VMIN, VMAX);
                    e_err = (int'(hb_in) != m_hb || int'(vb_in) != m_vb) ? 1 : 0;
                end else begin
                    m_v++;
                end
            end else begin
                m_h++;
            end
        end
    end

    // Compare all outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk((e_y < VA) ? "R2" : "R3", "de", int'(de), e_de);
            chk("R4", "px_x", int'(px_x), e_x);
            chk("R4", "px_y", int'(px_y), e_y);
            chk("R5", "frame_start", int'(frame_start), e_fs);
            chk("R6", "hsync", int'(hsync), 0);
            chk("R6", "vsync", int'(vsync), 0);
            chk("R10", "cfg_err", int'(cfg_err), e_err);
        end
    end

    // Advance to the next negedge where frame_start is seen.
    task automatic wait_fs();
        do @(negedge clk); while (!frame_start);
    endtask

    // From a frame_start negedge, count clocks to the next one.
    task automatic measure(output int len);
        len = 0;
        do begin
            @(negedge clk);
            len++;
        end while (!frame_start);
    endtask

    // Apply a setting, skip the frame in flight, then check error and length.
    task automatic run_cfg(input int hb, input int vb, input int exp_len,
                           input int exp_err, input string tag);
        int len;
        hb_in = HBW'(hb);
        vb_in = VBW'(vb);
        measure(len);
        chk(tag, "cfg_err at frame start", int'(cfg_err), exp_err);
        measure(len);
        chk(tag, "frame length", len, exp_len);
    endtask

    initial begin
        int len;
        repeat (3) @(negedge clk);
        // R1: outputs idle during reset, error from in-range inputs is 0
        chk("R1", "de in reset", int'(de), 0);
        chk("R1", "frame_start in reset", int'(frame_start), 0);
        chk("R1", "px_x in reset", int'(px_x), 0);
        chk("R1", "px_y in reset", int'(px_y), 0);
        chk("R1", "cfg_err in reset", int'(cfg_err), 0);
        rst_n = 1'b1;

        wait_fs();
        measure(len);
        chk("R2", "first frame length", len, (HA + 5) * (VA + 3));

        // R9: change in the middle of a frame, old length persists once
        hb_in = 4'd9; vb_in = 3'd4;
        measure(len);
        chk("R9", "frame after mid-frame change", len, (HA + 5) * (VA + 3));
        measure(len);
        chk("R9", "frame with new setting", len, (HA + 9) * (VA + 4));

        run_cfg(1, 3, (HA + HMIN) * (VA + 3), 1, "R7");
        run_cfg(15, 2, (HA + HMAX) * (VA + 2), 1, "R7");
        run_cfg(4, 0, (HA + 4) * (VA + VMIN), 1, "R8");
        run_cfg(3, 7, (HA + 3) * (VA + VMAX), 1, "R8");
        run_cfg(6, 2, (HA + 6) * (VA + 2), 0, "R10");

        // R10: error does not move until the frame boundary
        hb_in = 4'd0;
        repeat (5) @(negedge clk);
        chk("R10", "cfg_err mid-frame", int'(cfg_err), 0);
        wait_fs();
        chk("R10", "cfg_err next frame", int'(cfg_err), 1);

        // R1: reset mid-run loads inputs and clears outputs
        hb_in = 4'd6;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "de in second reset", int'(de), 0);
        chk("R1", "px_x in second reset", int'(px_x), 0);
        chk("R1", "cfg_err in second reset", int'(cfg_err), 0);
        rst_n = 1'b1;
        wait_fs();
        measure(len);
        chk("R1", "frame length after reset", len, (HA + 6) * (VA + 2));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule